// File: doc/BRIEF.md
# Step/Direction Microstepping Indexer

This block converts a step pulse train and a direction level into a position within one electrical cycle of a two-phase stepper motor, then reads the current reference for both phases at that position. Four waveforms are built in as constant tables. Two coarse ones drive each coil at full scale or not at all. Two fine ones follow a sine and a cosine with 8-bit magnitudes. A two-bit select chooses the active table. A downstream chopper samples the two signed references and regulates the coil currents to them.

One counter serves every table. It holds the position at the finest resolution, which is 32 positions per electrical cycle. The active table's entry is the top bits of that counter. A step moves the counter by one entry of the active table. A change of table clears the bits the new table cannot resolve, so the motor keeps the same electrical angle. The step and direction pins are asynchronous and pass through a synchronizer. The mode select and enable are synchronous control pins.

The references are held levels, not a stream. They carry no valid/ready handshake and have no back-pressure. The chopper may sample them on any cycle. `ref_on` marks whether they are in force.

Top module: `stepdir_indexer`

## Requirements
- R1: After reset, with `enable` high, `step_index` is 0 and the references show entry 0 of the selected table. In full-step mode this is phase A at +255 and phase B at 0.
- R2: Only a high-to-low transition of `step_in` moves the position, and each one moves it by exactly one entry. A rising edge or a steady level of either polarity leaves `step_index` unchanged.
- R3: `dir_in` = 1 at the falling edge moves the position up by one entry, and `dir_in` = 0 moves it down by one entry.
- R4: The position wraps modulo the active table length. That length is 4, 8, 16 or 32 for `mode_sel` values 0, 1, 2 and 3. Stepping up from the last entry gives 0, and stepping down from 0 gives the last entry.
- R5: Entry i of a table of length L stands for the electrical angle 360·i/L degrees. Phase A follows cos and phase B follows sin. In modes 2 and 3 the magnitude is round(255·|value|). In modes 0 and 1 it is 255 where the value is nonzero and 0 where it is zero. The sign bit is 1 for a negative value, and it is always 0 when the magnitude is 0.
- R6: While `enable` is low, falling edges of `step_in` are ignored and the position is kept. Both magnitudes and both sign bits read 0, and `ref_on` is 0. One cycle after `enable` returns high, the references of the kept position reappear and `ref_on` is 1.
- R7: `mode_sel` encodes 0 = full, 1 = half, 2 = quarter and 3 = eighth step. A change of `mode_sel` rescales the position to the same electrical angle. Moving to a coarser table divides the index by 2^d and rounds down. Moving to a finer table multiplies it by 2^d. The result is shown one clock after the change is sampled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| step_in | input | 1 | Step pulse, asynchronous; acts on its falling edge |
| dir_in | input | 1 | Direction, asynchronous; 1 = up, 0 = down |
| enable | input | 1 | Synchronous enable; low ignores steps and blanks the references |
| mode_sel | input | 2 | Drive table select: 0 full, 1 half, 2 quarter, 3 eighth |
| step_index | output | 5 | Current entry in the active table |
| ref_a_mag | output | 8 | Phase A reference magnitude |
| ref_a_neg | output | 1 | Phase A reference sign, 1 = negative |
| ref_b_mag | output | 8 | Phase B reference magnitude |
| ref_b_neg | output | 1 | Phase B reference sign, 1 = negative |
| ref_on | output | 1 | References in force |

## Verification
A falling step edge passes through two synchronizer flops and an edge register. The position, and with it the combinational table read, therefore changes on the third rising clock after `step_in` falls. A change on `mode_sel` or `enable` shows up after the next rising clock. The bench drives every input on the falling clock edge. After a step it waits four falling edges before sampling, and after a mode or enable change it waits one. Each sample falls after the due edge and before any further stimulus. Expected magnitudes come from a real-valued cos/sin model of the electrical angle, not from the block's tables.

// File: rtl/stepidx_pkg.sv
package stepidx_pkg;

  localparam int MODE_CNT  = 4;
  localparam int FINE_W    = 2 + MODE_CNT - 1;
  localparam int REF_MAG_W = 8;
  localparam int QTR_FINE  = 1 << (FINE_W - 2);

  typedef enum logic [1:0] {
    DRV_FULL    = 2'd0,
    DRV_HALF    = 2'd1,
    DRV_QUARTER = 2'd2,
    DRV_EIGHTH  = 2'd3
  } drive_mode_e;

  typedef struct packed {
    logic                 neg;
    logic [REF_MAG_W-1:0] mag;
  } phase_ref_t;

  // fine-position distance covered by one entry of the given table
  function automatic logic [FINE_W-1:0] stride(input drive_mode_e m);
    logic [FINE_W-1:0] one;
    one = 1;
    return one << (MODE_CNT - 1 - int'(m));
  endfunction

  // clears fine bits the given table cannot resolve
  function automatic logic [FINE_W-1:0] grid_mask(input drive_mode_e m);
    return ~(stride(m) - 1'b1);
  endfunction

  // |cos| at k * 11.25 degrees, k = 0..8, full scale 255
  function automatic logic [REF_MAG_W-1:0] quarter_cos(input logic [3:0] k);
    logic [7:0] v;
    case (k)
      4'd0:    v = 8'd255;
      4'd1:    v = 8'd250;
      4'd2:    v = 8'd236;
      4'd3:    v = 8'd212;
      4'd4:    v = 8'd180;
      4'd5:    v = 8'd142;
      4'd6:    v = 8'd98;
      4'd7:    v = 8'd50;
      default: v = 8'd0;
    endcase
    return REF_MAG_W'((32'(v) * ((1 << REF_MAG_W) - 1)) / 255);
  endfunction

  // signed cosine reference at fine angle f; square selects on/off drive
  function automatic phase_ref_t angle_ref(input logic [FINE_W-1:0] f, input logic square);
    phase_ref_t r;
    logic [3:0] k;
    logic       neg;
    logic [3:0] frac;
    frac = {1'b0, f[FINE_W-3:0]};
    case (f[FINE_W-1 -: 2])
      2'd0:    begin k = frac;         neg = 1'b0; end
      2'd1:    begin k = 4'd8 - frac;  neg = 1'b1; end
      2'd2:    begin k = frac;         neg = 1'b1; end
      default: begin k = 4'd8 - frac;  neg = 1'b0; end
    endcase
    r.mag = quarter_cos(k);
    if (square && r.mag != '0) r.mag = '1;
    r.neg = neg && (r.mag != '0);
    return r;
  endfunction

endpackage

// File: rtl/stepdir_sync.sv
module stepdir_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout,
  output logic [W-1:0] fall
);

  logic [W-1:0] stg [STAGES];
  logic [W-1:0] prev;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) stg[s] <= '0;
      prev <= '0;
    end else begin
      stg[0] <= din;
      for (int s = 1; s < STAGES; s++) stg[s] <= stg[s-1];
      prev <= stg[STAGES-1];
    end
  end

  assign dout = stg[STAGES-1];
  assign fall = prev & ~stg[STAGES-1];

endmodule

// File: rtl/stepdir_counter.sv
module stepdir_counter
  import stepidx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step_fall,
  input  logic              dir_s,
  input  logic              enable,
  input  logic [1:0]        mode_sel,
  output logic [FINE_W-1:0] fine_q,
  output drive_mode_e       mode_q
);

  drive_mode_e       mode_n;
  logic [FINE_W-1:0] moved;
  logic [FINE_W-1:0] fine_n;
  logic              same_mode;

  assign same_mode = (drive_mode_e'(mode_sel) == mode_q);

  always_comb begin
    mode_n = drive_mode_e'(mode_sel);
    moved  = fine_q;
    if (step_fall && enable)
      moved = dir_s ? fine_q + stride(mode_n) : fine_q - stride(mode_n);
    fine_n = moved & grid_mask(mode_n);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fine_q <= '0;
      mode_q <= DRV_FULL;
    end else begin
      fine_q <= fine_n;
      mode_q <= mode_n;
    end
  end

  AST_HOLD_NO_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    (!step_fall && same_mode) |=> $stable(fine_q)); // R2

  AST_HOLD_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
    (!enable && same_mode) |=> $stable(fine_q)); // R6

  AST_WRAP_UP: assert property (@(posedge clk) disable iff (!rst_n)
    (step_fall && enable && dir_s && same_mode && fine_q == grid_mask(mode_q))
    |=> (fine_q == '0)); // R4

  AST_WRAP_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    (step_fall && enable && !dir_s && same_mode && fine_q == '0)
    |=> (fine_q == grid_mask(mode_q))); // R4

  AST_RESCALE: assert property (@(posedge clk) disable iff (!rst_n)
    (!same_mode && !step_fall) |=> (fine_q == ($past(fine_q) & grid_mask(mode_q)))); // R7

endmodule

// File: rtl/stepdir_phase_rom.sv
module stepdir_phase_rom
  import stepidx_pkg::*;
#(
  parameter int MODE  = 0,
  parameter int IDX_W = 2 + MODE
) (
  input  logic [IDX_W-1:0] idx,
  output phase_ref_t       ref_a,
  output phase_ref_t       ref_b
);

  localparam int LEN = 1 << IDX_W;

  phase_ref_t tbl_a [LEN];
  phase_ref_t tbl_b [LEN];

  for (genvar i = 0; i < LEN; i++) begin : g_ent
    localparam logic [FINE_W-1:0] ANG_A = FINE_W'(i << (FINE_W - IDX_W));
    localparam logic [FINE_W-1:0] ANG_B = ANG_A - FINE_W'(QTR_FINE);
    assign tbl_a[i] = angle_ref(ANG_A, MODE < 2);
    assign tbl_b[i] = angle_ref(ANG_B, MODE < 2);
  end

  assign ref_a = tbl_a[idx];
  assign ref_b = tbl_b[idx];

endmodule

// File: rtl/stepdir_indexer.sv
module stepdir_indexer
  import stepidx_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 step_in,
  input  logic                 dir_in,
  input  logic                 enable,
  input  logic [1:0]           mode_sel,
  output logic [FINE_W-1:0]    step_index,
  output logic [REF_MAG_W-1:0] ref_a_mag,
  output logic                 ref_a_neg,
  output logic [REF_MAG_W-1:0] ref_b_mag,
  output logic                 ref_b_neg,
  output logic                 ref_on
);

  logic [1:0]        pins_s;
  logic [1:0]        pins_fall;
  logic [FINE_W-1:0] fine_q;
  drive_mode_e       mode_q;
  logic              en_q;
  phase_ref_t        rom_a [MODE_CNT];
  phase_ref_t        rom_b [MODE_CNT];
  phase_ref_t        sel_a;
  phase_ref_t        sel_b;

  stepdir_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  ({dir_in, step_in}),
    .dout (pins_s),
    .fall (pins_fall)
  );

  stepdir_counter u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .step_fall(pins_fall[0]),
    .dir_s    (pins_s[1]),
    .enable   (enable),
    .mode_sel (mode_sel),
    .fine_q   (fine_q),
    .mode_q   (mode_q)
  );

  for (genvar g = 0; g < MODE_CNT; g++) begin : g_tbl
    stepdir_phase_rom #(.MODE(g)) u_rom (
      .idx  (fine_q[FINE_W-1 -: 2+g]),
      .ref_a(rom_a[g]),
      .ref_b(rom_b[g])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) en_q <= 1'b0;
    else        en_q <= enable;
  end

  always_comb begin
    sel_a = rom_a[mode_q];
    sel_b = rom_b[mode_q];
    if (!en_q) begin
      sel_a = '0;
      sel_b = '0;
    end
  end

  assign step_index = fine_q >> (MODE_CNT - 1 - int'(mode_q));
  assign ref_a_mag  = sel_a.mag;
  assign ref_a_neg  = sel_a.neg;
  assign ref_b_mag  = sel_b.mag;
  assign ref_b_neg  = sel_b.neg;
  assign ref_on     = en_q;

  AST_ZERO_UNSIGNED_A: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_a_mag == '0) |-> !ref_a_neg); // R5

  AST_ZERO_UNSIGNED_B: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_b_mag == '0) |-> !ref_b_neg); // R5

  AST_INDEX_IN_TABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(step_index) < (4 << int'(mode_q)))); // R4

endmodule

// File: tb/stepdir_indexer_bench.sv
module stepdir_indexer_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       step_in = 1'b0;
  logic       dir_in = 1'b1;
  logic       enable = 1'b1;
  logic [1:0] mode_sel = 2'd0;
  logic [4:0] step_index;
  logic [7:0] ref_a_mag, ref_b_mag;
  logic       ref_a_neg, ref_b_neg, ref_on;

  int checks = 0;
  int errors = 0;
  int exp_idx = 0;
  int exp_mode = 0;
  bit exp_on = 1'b1;
  bit done = 1'b0;

  always #10 clk = ~clk;

  stepdir_indexer u_stepdir_indexer (
    .clk(clk), .rst_n(rst_n), .step_in(step_in), .dir_in(dir_in),
    .enable(enable), .mode_sel(mode_sel), .step_index(step_index),
    .ref_a_mag(ref_a_mag), .ref_a_neg(ref_a_neg),
    .ref_b_mag(ref_b_mag), .ref_b_neg(ref_b_neg), .ref_on(ref_on)
  );

  function automatic void model_ref(input int idx, input int m, input bit is_b,
                                    output int mag, output bit neg);
    real ang, v, a;
    ang = 2.0 * 3.14159265358979 * real'(idx) / real'(4 << m);
    v   = is_b ? $sin(ang) : $cos(ang);
    a   = (v < 0.0) ? -v : v;
    if (m < 2) mag = (a > 1.0e-6) ? 255 : 0;
    else       mag = $rtoi(255.0 * a + 0.5);
    neg = (v < -1.0e-6);
  endfunction

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic check_all(input string req);
    int am, bm;
    bit an, bn;
    model_ref(exp_idx, exp_mode, 1'b0, am, an);
    model_ref(exp_idx, exp_mode, 1'b1, bm, bn);
    if (!exp_on) begin am = 0; an = 0; bm = 0; bn = 0; end
    check(req, "step_index", int'(step_index), exp_idx);
    check(req, "ref_a_mag", int'(ref_a_mag), am);
    check(req, "ref_a_neg", int'(ref_a_neg), int'(an));
    check(req, "ref_b_mag", int'(ref_b_mag), bm);
    check(req, "ref_b_neg", int'(ref_b_neg), int'(bn));
    check(req, "ref_on", int'(ref_on), int'(exp_on));
  endtask

  task automatic pulse_step(input bit d);
    int len;
    @(negedge clk);
    dir_in  = d;
    step_in = 1'b1;
    repeat (4) @(negedge clk);
    step_in = 1'b0;
    repeat (4) @(negedge clk);
    len = 4 << exp_mode;
    if (enable) exp_idx = d ? (exp_idx + 1) % len : (exp_idx + len - 1) % len;
  endtask

  task automatic change_mode(input int m);
    @(negedge clk);
    mode_sel = 2'(m);
    @(negedge clk);
    if (m < exp_mode) exp_idx = exp_idx >> (exp_mode - m);
    else              exp_idx = exp_idx << (m - exp_mode);
    exp_mode = m;
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check_all("R1");
  endtask

  task automatic t_eighth_walk();
    change_mode(3);
    check_all("R7");
    for (int i = 0; i < 6; i++) begin
      pulse_step(1'b1);
      check_all("R3");
    end
    for (int i = 0; i < 20; i++) pulse_step(1'b1);
    check_all("R5");
  endtask

  task automatic t_levels_ignored();
    @(negedge clk);
    step_in = 1'b1;
    repeat (6) @(negedge clk);
    check("R2", "index after rising edge", int'(step_index), exp_idx);
    repeat (10) @(negedge clk);
    check("R2", "index while high", int'(step_index), exp_idx);
    step_in = 1'b0;
    repeat (4) @(negedge clk);
    exp_idx = (exp_idx + 1) % (4 << exp_mode);
    check_all("R2");
    repeat (10) @(negedge clk);
    check("R2", "index while low", int'(step_index), exp_idx);
  endtask

  task automatic t_wrap();
    change_mode(1);
    check_all("R7");
    while (exp_idx != 0) pulse_step(1'b0);
    pulse_step(1'b0);
    check_all("R4");
    pulse_step(1'b1);
    check_all("R4");
    change_mode(0);
    while (exp_idx != 3) pulse_step(1'b1);
    check_all("R5");
    pulse_step(1'b1);
    check_all("R4");
    change_mode(2);
    for (int i = 0; i < 5; i++) begin
      pulse_step(1'b0);
      check_all("R5");
    end
  endtask

  task automatic t_disable();
    int held;
    @(negedge clk);
    enable = 1'b0;
    exp_on = 1'b0;
    @(negedge clk);
    check_all("R6");
    held = exp_idx;
    pulse_step(1'b1);
    pulse_step(1'b1);
    check("R6", "index held while disabled", int'(step_index), held);
    check_all("R6");
    @(negedge clk);
    enable = 1'b1;
    exp_on = 1'b1;
    @(negedge clk);
    check_all("R6");
  endtask

  task automatic t_rescale();
    change_mode(3);
    while (exp_idx != 5) pulse_step(1'b1);
    check_all("R7");
    change_mode(1);
    check("R7", "eighth 5 to half", int'(step_index), 1);
    check_all("R7");
    change_mode(3);
    check("R7", "half 1 to eighth", int'(step_index), 4);
    check_all("R7");
  endtask

  initial begin
    t_reset();
    t_eighth_walk();
    t_levels_ignored();
    t_wrap();
    t_disable();
    t_rescale();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule